// File: doc/BRIEF.md
# Block Permutation and Byte Streaming for a 64-bit Feistel Cipher

This block sits between a byte-wide data path and a round engine that works on two 32-bit half-words. On the load side it takes eight bytes, one per cycle, over a valid/ready stream. It packs them into a left and a right half and passes them through the initial permutation. It then offers the permuted halves to the round engine on a parallel valid/ready port. On the unload side it takes the engine's final halves over a second parallel valid/ready port. It applies the inverse permutation and streams the result out as eight bytes, one per cycle.

Neither permutation is a bit-wiring table. Each is a fixed chain of masked delta-swaps between the two halves, together with single-bit rotations. The whole chain is combinational, so the permuted halves are present in the cycle after the eighth byte is captured.

Back-pressure rules are as follows. An input byte transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a complete block waits for the engine. Once `ip_valid` is high, it and both halves stay unchanged until `ip_ready` is seen high. The output byte transfers on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the byte on `out_byte` holds. `fp_ready` stays low from the moment a block is taken until its last byte has left.

Top module: `des_block_io`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `in_ready`=1, `fp_ready`=1, `ip_valid`=0 and `out_valid`=0. A block that is only partly loaded when reset is applied is discarded, and the next eight bytes form a fresh block.
- R2: Bytes are packed in arrival order. Bytes 0..3 fill the left half and bytes 4..7 fill the right half. Within each half the earlier byte is the more significant one (byte 0 is left[31:24], byte 4 is right[31:24]).
- R3: The initial permutation applies these steps in order. A swap step (a,b,s,m) computes t=((a>>s)^b)&m, then b^=t and a^=t<<s. The steps are:
  - swap(L,R,4,0x0f0f0f0f)
  - swap(L,R,16,0x0000ffff)
  - swap(R,L,2,0x33333333)
  - swap(R,L,8,0x00ff00ff)
  - rotate R left by 1
  - exchange the bits under 0xaaaaaaaa between L and R
  - rotate L left by 1

  The results appear on `ip_left`/`ip_right`.
- R4: `ip_valid` rises in the cycle after the eighth byte transfers, and never earlier. While `ip_valid` is high and `ip_ready` is low, `ip_valid`, `ip_left` and `ip_right` hold and `in_ready` is 0.
- R5: The inverse permutation applies these steps in order to `fp_left` (L) and `fp_right` (R):
  - rotate R right by 1
  - exchange the bits under 0xaaaaaaaa
  - rotate L right by 1
  - swap(L,R,8,0x00ff00ff)
  - swap(L,R,2,0x33333333)
  - swap(R,L,16,0x0000ffff)
  - swap(R,L,4,0x0f0f0f0f)
- R6: Output bytes 0..3 are R[31:24] down to R[7:0] of the inversely permuted halves. Output bytes 4..7 are taken from L in the same order.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_byte` hold, and no byte is lost.
- R8: `fp_ready` is 0 from the cycle after a block is taken on the `fp` port until the cycle after its eighth byte transfers. A block offered in that window does not alter the bytes being sent.
- R9: Feeding the permuted halves back exchanged (`fp_left`=`ip_right`, `fp_right`=`ip_left`) reproduces the original eight bytes in order.
- R10: With valid and ready held high, eight bytes load in eight consecutive cycles. A taken block is likewise sent in eight consecutive cycles, with `out_valid` rising in the cycle after the `fp` handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts an input byte |
| in_byte | input | 8 | Input byte |
| ip_valid | output | 1 | Permuted halves present for the round engine |
| ip_ready | input | 1 | Round engine takes the halves |
| ip_left | output | 32 | Left half after the initial permutation |
| ip_right | output | 32 | Right half after the initial permutation |
| fp_valid | input | 1 | Final halves present from the round engine |
| fp_ready | output | 1 | Block accepts final halves |
| fp_left | input | 32 | Final left half |
| fp_right | input | 32 | Final right half |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes the output byte |
| out_byte | output | 8 | Output byte |

## Verification
A wrong byte counter in the loader shows up within one block. `ip_valid` either rises before or after the eighth transfer, or the halves come out with bytes shifted. A wrong mask, shift or step order in either chain corrupts `ip_left`/`ip_right` in the first cycle they are valid, or corrupts the first unloaded byte. It also breaks the round trip in R9 for any block with enough set bits. An unloader that drops its hold or its busy state shows up as a changed `out_byte` during a stall, as a byte count other than eight, or as `fp_ready` rising mid-block.

// File: rtl/des_io_pkg.sv
package des_io_pkg;

  localparam int HALF_W = 32;
  localparam int NSTEPS = 7;

  typedef enum logic [2:0] {
    OP_SWAP_LR,   // t from left shifted, applied to right
    OP_SWAP_RL,   // t from right shifted, applied to left
    OP_ROTL_L,
    OP_ROTL_R,
    OP_ROTR_L,
    OP_ROTR_R,
    OP_XCHG
  } step_op_e;

  typedef struct packed {
    step_op_e    op;
    logic [4:0]  sh;
    logic [31:0] mask;
  } step_t;

  typedef struct packed {
    logic [HALF_W-1:0] l;
    logic [HALF_W-1:0] r;
  } halves_t;

  function automatic step_t mk(step_op_e op, logic [4:0] sh, logic [31:0] mask);
    step_t s;
    s.op = op;
    s.sh = sh;
    s.mask = mask;
    return s;
  endfunction

  // Initial permutation sequence
  function automatic step_t fwd_step(int idx);
    case (idx)
      0:       return mk(OP_SWAP_LR, 5'd4,  32'h0f0f0f0f);
      1:       return mk(OP_SWAP_LR, 5'd16, 32'h0000ffff);
      2:       return mk(OP_SWAP_RL, 5'd2,  32'h33333333);
      3:       return mk(OP_SWAP_RL, 5'd8,  32'h00ff00ff);
      4:       return mk(OP_ROTL_R,  5'd1,  32'h0);
      5:       return mk(OP_XCHG,    5'd0,  32'haaaaaaaa);
      default: return mk(OP_ROTL_L,  5'd1,  32'h0);
    endcase
  endfunction

  // Inverse permutation sequence
  function automatic step_t inv_step(int idx);
    case (idx)
      0:       return mk(OP_ROTR_R,  5'd1,  32'h0);
      1:       return mk(OP_XCHG,    5'd0,  32'haaaaaaaa);
      2:       return mk(OP_ROTR_L,  5'd1,  32'h0);
      3:       return mk(OP_SWAP_LR, 5'd8,  32'h00ff00ff);
      4:       return mk(OP_SWAP_LR, 5'd2,  32'h33333333);
      5:       return mk(OP_SWAP_RL, 5'd16, 32'h0000ffff);
      default: return mk(OP_SWAP_RL, 5'd4,  32'h0f0f0f0f);
    endcase
  endfunction

  function automatic halves_t apply_step(step_t s, halves_t h);
    halves_t o;
    logic [HALF_W-1:0] t;
    o = h;
    case (s.op)
      OP_SWAP_LR: begin
        t   = ((h.l >> s.sh) ^ h.r) & s.mask;
        o.r = h.r ^ t;
        o.l = h.l ^ (t << s.sh);
      end
      OP_SWAP_RL: begin
        t   = ((h.r >> s.sh) ^ h.l) & s.mask;
        o.l = h.l ^ t;
        o.r = h.r ^ (t << s.sh);
      end
      OP_ROTL_L: o.l = {h.l[HALF_W-2:0], h.l[HALF_W-1]};
      OP_ROTL_R: o.r = {h.r[HALF_W-2:0], h.r[HALF_W-1]};
      OP_ROTR_L: o.l = {h.l[0], h.l[HALF_W-1:1]};
      OP_ROTR_R: o.r = {h.r[0], h.r[HALF_W-1:1]};
      default: begin
        t   = (h.l ^ h.r) & s.mask;
        o.l = h.l ^ t;
        o.r = h.r ^ t;
      end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/des_perm_chain.sv
module des_perm_chain
  import des_io_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  halves_t din,
  output halves_t dout
);

  halves_t stage [NSTEPS+1];

  assign stage[0] = din;

  for (genvar g = 0; g < NSTEPS; g++) begin : g_step
    localparam step_t ST = INVERSE ? inv_step(g) : fwd_step(g);
    assign stage[g+1] = apply_step(ST, stage[g]);
  end

  assign dout = stage[NSTEPS];

endmodule

// File: rtl/des_byte_collect.sv
module des_byte_collect #(
  parameter int BYTE_W = 8,
  parameter int BLK_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [BLK_W-1:0]  blk
);

  localparam int NBYTES = BLK_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] shreg;
  logic             full;
  logic             take;

  assign in_ready  = !full;
  assign take      = in_valid && !full;
  assign blk_valid = full;
  assign blk       = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      full <= 1'b0;
    end else begin
      if (take) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          full <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (full && blk_ready) full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) shreg <= {shreg[BLK_W-BYTE_W-1:0], in_byte};
  end

endmodule

// File: rtl/des_byte_emit.sv
module des_byte_emit #(
  parameter int BYTE_W = 8,
  parameter int BLK_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_valid,
  output logic              blk_ready,
  input  logic [BLK_W-1:0]  blk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte
);

  localparam int NBYTES = BLK_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0] idx;
  logic [BLK_W-1:0] shreg;
  logic             busy;

  assign blk_ready = !busy;
  assign out_valid = busy;
  assign out_byte  = shreg[BLK_W-1 -: BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (blk_valid) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (out_ready) begin
      if (idx == LAST) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && blk_valid)    shreg <= blk;
    else if (busy && out_ready) shreg <= {shreg[BLK_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
  end

endmodule

// File: rtl/des_block_io.sv
module des_block_io
  import des_io_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              ip_valid,
  input  logic              ip_ready,
  output logic [31:0]       ip_left,
  output logic [31:0]       ip_right,
  input  logic              fp_valid,
  output logic              fp_ready,
  input  logic [31:0]       fp_left,
  input  logic [31:0]       fp_right,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte
);

  localparam int BLK_W = 2 * HALF_W;

  logic [BLK_W-1:0] in_blk;
  logic [BLK_W-1:0] out_blk;
  halves_t          fwd_in, fwd_out, inv_in, inv_out;

  des_byte_collect #(.BYTE_W(BYTE_W), .BLK_W(BLK_W)) i_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_byte  (in_byte),
    .blk_valid(ip_valid),
    .blk_ready(ip_ready),
    .blk      (in_blk)
  );

  // Earlier bytes are more significant; upper half is left
  assign fwd_in.l = in_blk[BLK_W-1:HALF_W];
  assign fwd_in.r = in_blk[HALF_W-1:0];

  des_perm_chain #(.INVERSE(1'b0)) i_fwd (.din(fwd_in), .dout(fwd_out));

  assign ip_left  = fwd_out.l;
  assign ip_right = fwd_out.r;

  assign inv_in.l = fp_left;
  assign inv_in.r = fp_right;

  des_perm_chain #(.INVERSE(1'b1)) i_inv (.din(inv_in), .dout(inv_out));

  // Right half leaves first
  assign out_blk = {inv_out.r, inv_out.l};

  des_byte_emit #(.BYTE_W(BYTE_W), .BLK_W(BLK_W)) i_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_valid(fp_valid),
    .blk_ready(fp_ready),
    .blk      (out_blk),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_byte (out_byte)
  );

endmodule

// File: rtl/des_block_io_chk.sv
module des_block_io_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BYTE_W-1:0] in_byte,
  input logic              ip_valid,
  input logic              ip_ready,
  input logic [31:0]       ip_left,
  input logic [31:0]       ip_right,
  input logic              fp_valid,
  input logic              fp_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_byte
);

  logic [4:0] in_cnt;
  logic [4:0] out_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (ip_valid && ip_ready)     in_cnt <= '0;
      else if (in_valid && in_ready) in_cnt <= in_cnt + 1'b1;
      if (fp_valid && fp_ready)       out_cnt <= '0;
      else if (out_valid && out_ready) out_cnt <= out_cnt + 1'b1;
    end
  end

  // R1: outputs idle after a reset cycle
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !ip_valid && !out_valid && in_ready && fp_ready);

  // R4: block handed over only after eight transfers
  a_r4_full_block: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ip_valid) |-> in_cnt == 5'd8);

  a_r4_ip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ip_valid && !ip_ready |=> ip_valid && $stable(ip_left) && $stable(ip_right));

  a_r4_no_input_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    ip_valid |-> !in_ready);

  // R7: output stall holds the byte
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  // R8: no new block while unloading; exactly eight bytes leave
  a_r8_no_fp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !fp_ready);

  a_r8_eight_out: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> out_cnt == 5'd8);

endmodule

bind des_block_io des_block_io_chk #(.BYTE_W(BYTE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_byte(in_byte), .ip_valid(ip_valid), .ip_ready(ip_ready),
  .ip_left(ip_left), .ip_right(ip_right), .fp_valid(fp_valid),
  .fp_ready(fp_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte)
);

// File: tb/test_des_block_io.sv
`timescale 1ns/1ps
module test_des_block_io;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        ip_valid;
  logic        ip_ready = 1'b0;
  logic [31:0] ip_left, ip_right;
  logic        fp_valid = 1'b0;
  logic        fp_ready;
  logic [31:0] fp_left = '0, fp_right = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_byte;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  des_block_io i_des_block_io (.*);

  localparam logic [63:0] VEC [6] = '{
    64'h0000000000000000,
    64'hffffffffffffffff,
    64'h0123456789abcdef,
    64'h8000000000000001,
    64'hdeadbeefcafef00d,
    64'h5a5a0ff0a5a5f00f
  };

  function automatic logic [63:0] m_fwd(logic [63:0] b);
    logic [31:0] x, y, t;
    x = b[63:32]; y = b[31:0];
    t = ((x >> 4) ^ y) & 32'h0f0f0f0f;  y ^= t; x ^= (t << 4);
    t = ((x >> 16) ^ y) & 32'h0000ffff; y ^= t; x ^= (t << 16);
    t = ((y >> 2) ^ x) & 32'h33333333;  x ^= t; y ^= (t << 2);
    t = ((y >> 8) ^ x) & 32'h00ff00ff;  x ^= t; y ^= (t << 8);
    y = {y[30:0], y[31]};
    t = (x ^ y) & 32'haaaaaaaa; x ^= t; y ^= t;
    x = {x[30:0], x[31]};
    return {x, y};
  endfunction

  function automatic logic [63:0] m_inv(logic [31:0] xl, logic [31:0] yr);
    logic [31:0] x, y, t;
    x = xl; y = yr;
    y = {y[0], y[31:1]};
    t = (x ^ y) & 32'haaaaaaaa; x ^= t; y ^= t;
    x = {x[0], x[31:1]};
    t = ((x >> 8) ^ y) & 32'h00ff00ff;  y ^= t; x ^= (t << 8);
    t = ((x >> 2) ^ y) & 32'h33333333;  y ^= t; x ^= (t << 2);
    t = ((y >> 16) ^ x) & 32'h0000ffff; x ^= t; y ^= (t << 16);
    t = ((y >> 4) ^ x) & 32'h0f0f0f0f;  x ^= t; y ^= (t << 4);
    return {y, x};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_block(input logic [63:0] b, output int cycles);
    logic rdy;
    cycles = 0;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1;
      in_byte  = b[63-8*i -: 8];
      do begin
        rdy = in_ready;
        @(negedge clk);
        cycles++;
      end while (!rdy);
    end
    in_valid = 1'b0;
  endtask

  task automatic take_ip(output logic [31:0] l, output logic [31:0] r);
    while (!ip_valid) @(negedge clk);
    l = ip_left; r = ip_right;
    ip_ready = 1'b1;
    @(negedge clk);
    ip_ready = 1'b0;
  endtask

  task automatic give_fp(input logic [31:0] l, input logic [31:0] r);
    logic rdy;
    fp_valid = 1'b1; fp_left = l; fp_right = r;
    do begin
      rdy = fp_ready;
      @(negedge clk);
    end while (!rdy);
    fp_valid = 1'b0;
  endtask

  task automatic pop_block(output logic [63:0] b, output int cycles);
    cycles = 0;
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      while (!out_valid) begin
        @(negedge clk);
        cycles++;
      end
      b[63-8*i -: 8] = out_byte;
      @(negedge clk);
      cycles++;
    end
    out_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] l, r;
    logic [63:0] got;
    int cyc;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {60'd0, in_ready, fp_ready, ip_valid, out_valid},
          {60'd0, 1'b1, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {60'd0, in_ready, fp_ready, ip_valid, out_valid},
          {60'd0, 1'b1, 1'b1, 1'b0, 1'b0});

    // Table walk: R2, R3, R5, R6, R9, R10
    foreach (VEC[k]) begin
      push_block(VEC[k], cyc);
      check("R10 load cycles", 64'(cyc), 64'd8);
      check("R4 ip_valid after 8th byte", {63'd0, ip_valid}, 64'd1);
      take_ip(l, r);
      check("R2 R3 initial permutation", {l, r}, m_fwd(VEC[k]));
      give_fp(r, l);
      pop_block(got, cyc);
      check("R9 round trip", got, VEC[k]);
      check("R10 unload cycles", 64'(cyc), 64'd8);
    end

    // R5 R6: inverse permutation on arbitrary halves
    give_fp(32'h13579bdf, 32'h2468ace0);
    pop_block(got, cyc);
    check("R5 R6 inverse permutation and byte order", got, m_inv(32'h13579bdf, 32'h2468ace0));

    // R4: ip_valid not raised after seven bytes; hold under back-pressure
    for (int i = 0; i < 7; i++) begin
      in_valid = 1'b1; in_byte = 8'(8'h30 + i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 no ip_valid after seven bytes", {63'd0, ip_valid}, 64'd0);
    in_valid = 1'b1; in_byte = 8'h37;
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'hee;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check("R4 in_ready low while held", {63'd0, in_ready}, 64'd0);
    check("R4 halves hold", {ip_left, ip_right}, m_fwd(64'h3031323334353637));
    take_ip(l, r);

    // R1: reset discards a partial block
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1; in_byte = 8'hff;
      @(negedge clk);
    end
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push_block(64'h1122334455667788, cyc);
    take_ip(l, r);
    check("R1 partial block discarded", {l, r}, m_fwd(64'h1122334455667788));

    // R7 R8: stall during unload and a competing fp block
    give_fp(32'h0badf00d, 32'h600dcafe);
    got = m_inv(32'h0badf00d, 32'h600dcafe);
    fp_valid = 1'b1; fp_left = 32'hffffffff; fp_right = 32'h00000000;
    repeat (4) @(negedge clk);
    check("R7 out_valid held in stall", {63'd0, out_valid}, 64'd1);
    check("R7 byte held in stall", {56'd0, out_byte}, {56'd0, got[63:56]});
    check("R8 fp_ready low while unloading", {63'd0, fp_ready}, 64'd0);
    begin
      logic [63:0] g2;
      int c2;
      pop_block(g2, c2);
      check("R8 competing block did not disturb bytes", g2, got);
    end
    check("R8 fp_ready back after last byte", {63'd0, fp_ready}, 64'd1);
    fp_valid = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule